// File: doc/BRIEF.md
# Bus Transaction Phase Monitor

This block watches a 32-bit bus on which address and data share the same lines. It never drives the bus. On each clock it samples the bus and works out whether that clock was idle, an address phase, a data phase, or the turnaround after the last word. When an address phase is seen, it stores the address. It also decodes the 4-bit command/byte-enable lines into a transaction kind, a write flag and a reserved-code flag.

In the data phases, the same 4 lines carry active-low byte enables. A word is counted only in a clock where both the initiator-ready and target-ready handshakes are low. For each such word the monitor gives a one-clock strobe with the data, active-high byte enables and a running beat count. The word that moves while the frame signal is high is the last one. It raises an end pulse together with its strobe.

Every output is registered. Each output reports the bus clock sampled at the edge that loaded it, so it is one clock behind the bus. The block is meant for protocol checkers, trace capture and performance counters that sit beside a bus master or target.

Top module: `bus_phase_monitor`

## Requirements
- R1: While the synchronous active-high `rst` is sampled high, all of these outputs are zero after the edge: `bus_phase`, `xfer_valid`, `txn_end`, `beat_count`, `txn_kind`, `txn_addr`, `txn_write` and `txn_reserved`. The monitor also returns to idle.
- R2: The monitor may be idle, either after reset or after a turnaround has finished. If it is idle and samples `frame_n` low, that clock is an address phase. After the edge, `bus_phase` reads 1 and `txn_addr` holds `bus_ad`. Every later clock of the transaction, up to its last word, reports `bus_phase` = 2.
- R3: At an address phase, `bus_cbe_n` is decoded into `txn_kind`. The mapping from command code to kind is: 0000→1 (interrupt acknowledge), 0001→2 (special cycle), 0010→3 (I/O read), 0011→4 (I/O write), 0110→5 (memory read), 0111→6 (memory write), 1010→7 (config read), 1011→8 (config write), 1100→9 (memory read multiple), 1101→10 (dual address), 1110→11 (memory read line), 1111→12 (memory write and invalidate). The kind holds until the next address phase.
- R4: The command codes 0100, 0101, 1000 and 1001 give `txn_kind` = 13 and `txn_reserved` = 1. Every other code gives `txn_reserved` = 0.
- R5: `txn_write` is 1 for exactly these kinds: I/O write, memory write, config write, and memory write and invalidate. For all other kinds it is 0.
- R6: In a data-phase clock where `irdy_n` and `trdy_n` are both low, the next edge sets `xfer_valid` to 1. It also loads `xfer_data` with `bus_ad` and `xfer_be` with the bitwise inverse of `bus_cbe_n`. Bit 0 of `xfer_be` covers `bus_ad[7:0]` and bit 3 covers `bus_ad[31:24]`.
- R7: In a data-phase clock where either `irdy_n` or `trdy_n` is high, no strobe is given and `beat_count` keeps its value.
- R8: `beat_count` is cleared to 0 by an address phase. It steps up by one with each transferred word, so it shows the number of the word being strobed, counting from 1.
- R9: A word that transfers while `frame_n` is high ends the transaction. `txn_end` pulses together with that word's strobe. Each following clock reports `bus_phase` = 3, up to and including the first clock in which `irdy_n` is high. The monitor is then idle.
- R10: During the turnaround, a low `frame_n` does not start an address phase.
- R11: Suppose a clock has `frame_n` high and `irdy_n` low, but `trdy_n` high. That clock is a wait state: it does not end the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_ad | input | 32 | Shared address/data lines |
| bus_cbe_n | input | 4 | Command (address phase) or active-low byte enables (data phase) |
| frame_n | input | 1 | Active-low frame signal from the initiator |
| irdy_n | input | 1 | Active-low initiator-ready |
| trdy_n | input | 1 | Active-low target-ready |
| bus_phase | output | 2 | Phase of the sampled clock: 0 idle, 1 address, 2 data, 3 turnaround |
| txn_addr | output | 32 | Address captured at the last address phase |
| txn_kind | output | 4 | Decoded transaction kind (see R3, R4) |
| txn_write | output | 1 | Write direction of the current transaction |
| txn_reserved | output | 1 | The command code was a reserved one |
| xfer_valid | output | 1 | One-clock strobe per transferred word |
| xfer_data | output | 32 | Data of the strobed word |
| xfer_be | output | 4 | Active-high byte enables of the strobed word |
| beat_count | output | 16 | Number of the strobed word within the transaction |
| txn_end | output | 1 | Pulses with the strobe of the final word |

## Verification
The hardest case to reach is the last-word handshake. The initiator has already raised `frame_n` and holds `irdy_n` low, while the target is still inserting waits. Both the end decision and the beat count hinge on that cycle. The stimulus task can put a wait clock of exactly that shape before the final word. It can also stretch the turnaround with `irdy_n` held low while `frame_n` is driven low, which shows that no new address phase is taken until release. A reset in the middle of a burst and a sweep over all sixteen command codes cover the remaining corners.

// File: rtl/bm_pkg.sv
package bm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_TURN = 2'd3
    } bm_phase_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DATA = 2'd1,
        S_DONE = 2'd2
    } bm_state_e;

    typedef enum logic [3:0] {
        K_NONE        = 4'd0,
        K_INTACK      = 4'd1,
        K_SPECIAL     = 4'd2,
        K_IO_RD       = 4'd3,
        K_IO_WR       = 4'd4,
        K_MEM_RD      = 4'd5,
        K_MEM_WR      = 4'd6,
        K_CFG_RD      = 4'd7,
        K_CFG_WR      = 4'd8,
        K_MEM_RD_MULT = 4'd9,
        K_DUAL_ADDR   = 4'd10,
        K_MEM_RD_LINE = 4'd11,
        K_MEM_WR_INV  = 4'd12,
        K_RESERVED    = 4'd13
    } bm_kind_e;

    typedef struct packed {
        bm_kind_e kind;
        logic     is_write;
        logic     reserved;
    } bm_cmd_info_t;

    function automatic bm_kind_e kind_of(input logic [3:0] code);
        bm_kind_e k;
        case (code)
            4'b0000: k = K_INTACK;
            4'b0001: k = K_SPECIAL;
            4'b0010: k = K_IO_RD;
            4'b0011: k = K_IO_WR;
            4'b0110: k = K_MEM_RD;
            4'b0111: k = K_MEM_WR;
            4'b1010: k = K_CFG_RD;
            4'b1011: k = K_CFG_WR;
            4'b1100: k = K_MEM_RD_MULT;
            4'b1101: k = K_DUAL_ADDR;
            4'b1110: k = K_MEM_RD_LINE;
            4'b1111: k = K_MEM_WR_INV;
            default: k = K_RESERVED;
        endcase
        return k;
    endfunction

    function automatic logic kind_writes(input bm_kind_e k);
        return (k == K_IO_WR) || (k == K_MEM_WR) ||
               (k == K_CFG_WR) || (k == K_MEM_WR_INV);
    endfunction

    function automatic bm_cmd_info_t decode_cmd(input logic [3:0] code);
        bm_cmd_info_t info;
        info.kind     = kind_of(code);
        info.is_write = kind_writes(info.kind);
        info.reserved = (info.kind == K_RESERVED);
        return info;
    endfunction

endpackage

// File: rtl/bm_phase_fsm.sv
module bm_phase_fsm
    import bm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      frame_n_i,
    input  logic      irdy_n_i,
    input  logic      trdy_n_i,
    output logic      start_o,
    output logic      beat_o,
    output logic      last_o,
    output bm_phase_e phase_o
);

    bm_state_e st_q, st_d;
    bm_phase_e phase_d;
    logic      hs;

    always_comb begin
        hs      = !irdy_n_i && !trdy_n_i;
        start_o = 1'b0;
        beat_o  = 1'b0;
        last_o  = 1'b0;
        st_d    = st_q;
        phase_d = PH_IDLE;
        case (st_q)
            S_IDLE: begin
                if (!frame_n_i) begin
                    start_o = 1'b1;
                    phase_d = PH_ADDR;
                    st_d    = S_DATA;
                end
            end
            S_DATA: begin
                phase_d = PH_DATA;
                if (hs) begin
                    beat_o = 1'b1;
                    if (frame_n_i) begin
                        last_o = 1'b1;
                        st_d   = S_DONE;
                    end
                end
            end
            S_DONE: begin
                phase_d = PH_TURN;
                if (irdy_n_i) st_d = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            phase_o <= PH_IDLE;
        end else begin
            st_q    <= st_d;
            phase_o <= phase_d;
        end
    end

    AST_TURN_WAITS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_TURN && $past(!irdy_n_i)) |-> ($past(st_q) == S_DONE || $past(st_q) == S_DATA)); // R9

endmodule

// File: rtl/bm_cmd_capture.sv
module bm_cmd_capture
    import bm_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = AD_W / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_n_i,
    output logic [AD_W-1:0]  addr_o,
    output bm_cmd_info_t     info_o
);

    localparam int CMD_W = 4;

    bm_cmd_info_t info_d;

    always_comb info_d = decode_cmd(cbe_n_i[CMD_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o <= '0;
            info_o <= '{kind: K_NONE, is_write: 1'b0, reserved: 1'b0};
        end else if (start_i) begin
            addr_o <= ad_i;
            info_o <= info_d;
        end
    end

    AST_RESERVED_NOT_WRITE: assert property (@(posedge clk) disable iff (rst)
        info_o.reserved |-> !info_o.is_write); // R4

    AST_HOLD_BETWEEN_STARTS: assert property (@(posedge clk) disable iff (rst)
        (!$past(start_i) && !$past(rst)) |-> $stable(addr_o)); // R2

endmodule

// File: rtl/bm_beat_tracker.sv
module bm_beat_tracker #(
    parameter int AD_W  = 32,
    parameter int CBE_W = AD_W / 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             beat_i,
    input  logic             last_i,
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_n_i,
    output logic             valid_o,
    output logic [AD_W-1:0]  data_o,
    output logic [CBE_W-1:0] be_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             end_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            end_o   <= 1'b0;
            cnt_o   <= '0;
            data_o  <= '0;
            be_o    <= '0;
        end else begin
            valid_o <= beat_i;
            end_o   <= last_i;
            if (start_i) begin
                cnt_o <= '0;
            end else if (beat_i) begin
                cnt_o  <= cnt_o + ONE;
                data_o <= ad_i;
                be_o   <= ~cbe_n_i;
            end
        end
    end

    AST_WAIT_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !beat_i) |=> $stable(cnt_o)); // R7

endmodule

// File: rtl/bus_phase_monitor.sv
module bus_phase_monitor
    import bm_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CNT_W = 16,
    localparam int CBE_W = AD_W / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AD_W-1:0]  bus_ad,
    input  logic [CBE_W-1:0] bus_cbe_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             trdy_n,
    output logic [1:0]       bus_phase,
    output logic [AD_W-1:0]  txn_addr,
    output logic [3:0]       txn_kind,
    output logic             txn_write,
    output logic             txn_reserved,
    output logic             xfer_valid,
    output logic [AD_W-1:0]  xfer_data,
    output logic [CBE_W-1:0] xfer_be,
    output logic [CNT_W-1:0] beat_count,
    output logic             txn_end
);

    logic         start_w, beat_w, last_w;
    bm_phase_e    phase_w;
    bm_cmd_info_t info_w;

    bm_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .frame_n_i (frame_n),
        .irdy_n_i  (irdy_n),
        .trdy_n_i  (trdy_n),
        .start_o   (start_w),
        .beat_o    (beat_w),
        .last_o    (last_w),
        .phase_o   (phase_w)
    );

    bm_cmd_capture #(.AD_W(AD_W), .CBE_W(CBE_W)) u_cmd (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_w),
        .ad_i    (bus_ad),
        .cbe_n_i (bus_cbe_n),
        .addr_o  (txn_addr),
        .info_o  (info_w)
    );

    bm_beat_tracker #(.AD_W(AD_W), .CBE_W(CBE_W), .CNT_W(CNT_W)) u_beat (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_w),
        .beat_i  (beat_w),
        .last_i  (last_w),
        .ad_i    (bus_ad),
        .cbe_n_i (bus_cbe_n),
        .valid_o (xfer_valid),
        .data_o  (xfer_data),
        .be_o    (xfer_be),
        .cnt_o   (beat_count),
        .end_o   (txn_end)
    );

    assign bus_phase    = phase_w;
    assign txn_kind     = info_w.kind;
    assign txn_write    = info_w.is_write;
    assign txn_reserved = info_w.reserved;

    AST_STROBE_NEEDS_HS: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> $past(!irdy_n && !trdy_n)); // R6

    AST_STROBE_HAS_COUNT: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> (beat_count != '0)); // R8

    AST_END_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
        txn_end |-> (xfer_valid && $past(frame_n))); // R9

    AST_END_TO_TURN: assert property (@(posedge clk) disable iff (rst)
        txn_end |=> (bus_phase == PH_TURN)); // R9

    AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
        (bus_phase == PH_ADDR) |=> (bus_phase == PH_DATA)); // R2

    AST_ADDR_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (bus_phase == PH_ADDR) |-> ($past(bus_phase) != PH_DATA && $past(bus_phase) != PH_ADDR)); // R10

endmodule

// File: tb/sim_bus_phase_monitor.sv
`timescale 1ns/1ps
module sim_bus_phase_monitor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_ad = '0;
    logic [3:0]  bus_cbe_n = '1;
    logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;

    logic [1:0]  bus_phase;
    logic [31:0] txn_addr, xfer_data;
    logic [3:0]  txn_kind, xfer_be;
    logic        txn_write, txn_reserved, xfer_valid, txn_end;
    logic [15:0] beat_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    bus_phase_monitor u0 (
        .clk(clk), .rst(rst), .bus_ad(bus_ad), .bus_cbe_n(bus_cbe_n),
        .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
        .bus_phase(bus_phase), .txn_addr(txn_addr), .txn_kind(txn_kind),
        .txn_write(txn_write), .txn_reserved(txn_reserved),
        .xfer_valid(xfer_valid), .xfer_data(xfer_data), .xfer_be(xfer_be),
        .beat_count(beat_count), .txn_end(txn_end)
    );

    // reference model state
    int          m_st = 0;            // 0 idle, 1 data, 2 turnaround
    int          e_phase = 0, e_cnt = 0;
    logic [31:0] e_addr = '0, e_data = '0;
    logic [3:0]  e_kind = '0, e_be = '0;
    bit          e_wr = 0, e_res = 0, e_xv = 0, e_end = 0;

    function automatic int kind_ref(input logic [3:0] c);   // R3, R4 table
        case (c)
            4'b0000: return 1;  4'b0001: return 2;  4'b0010: return 3;
            4'b0011: return 4;  4'b0110: return 5;  4'b0111: return 6;
            4'b1010: return 7;  4'b1011: return 8;  4'b1100: return 9;
            4'b1101: return 10; 4'b1110: return 11; 4'b1111: return 12;
            default: return 13;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int prev_st;
        prev_st = m_st;
        e_xv = 0; e_end = 0;
        if (rst) begin
            m_st = 0; e_phase = 0; e_cnt = 0; e_addr = '0; e_kind = '0;
            e_wr = 0; e_res = 0;
        end else begin
            case (m_st)
                0: begin
                    if (!frame_n) begin
                        e_phase = 1; e_addr = bus_ad; e_kind = 4'(kind_ref(bus_cbe_n));
                        e_res = (e_kind == 13);
                        e_wr = (e_kind == 4 || e_kind == 6 || e_kind == 8 || e_kind == 12);
                        e_cnt = 0; m_st = 1;
                    end else e_phase = 0;
                end
                1: begin
                    e_phase = 2;
                    if (!irdy_n && !trdy_n) begin
                        e_xv = 1; e_data = bus_ad; e_be = ~bus_cbe_n; e_cnt++;
                        if (frame_n) begin e_end = 1; m_st = 2; end
                    end
                end
                default: begin
                    e_phase = 3;
                    if (irdy_n) m_st = 0;
                end
            endcase
        end
        #2;
        if (rst) begin
            chk("R1", "phase", bus_phase, 0);
            chk("R1", "xfer_valid", xfer_valid, 0);
            chk("R1", "txn_end", txn_end, 0);
            chk("R1", "beat_count", beat_count, 0);
            chk("R1", "kind", txn_kind, 0);
            chk("R1", "addr", txn_addr, 0);
            chk("R1", "write", txn_write, 0);
            chk("R1", "reserved", txn_reserved, 0);
        end else begin
            chk(prev_st == 2 ? "R10" : "R2", "phase", bus_phase, e_phase);
            chk("R2", "addr", txn_addr, e_addr);
            chk("R3", "kind", txn_kind, e_kind);
            chk("R4", "reserved", txn_reserved, e_res);
            chk("R5", "write", txn_write, e_wr);
            chk((prev_st == 1 && !e_xv) ? "R7" : "R6", "xfer_valid", xfer_valid, e_xv);
            chk((prev_st == 1 && !e_xv) ? "R7" : "R8", "beat_count", beat_count, e_cnt);
            chk(e_end ? "R9" : "R11", "txn_end", txn_end, e_end);
            if (e_xv) begin
                chk("R6", "data", xfer_data, e_data);
                chk("R6", "byte_en", xfer_be, e_be);
            end
        end
    end

    task automatic drive(input bit f, input bit i, input bit t, input logic [31:0] ad, input logic [3:0] cbe);
        @(negedge clk);
        frame_n = f; irdy_n = i; trdy_n = t; bus_ad = ad; bus_cbe_n = cbe;
    endtask

    // mode 0: no waits; 1: initiator waits; 2: target waits; 3: R11 wait before final word
    task automatic do_txn(input logic [31:0] a, input logic [3:0] cmd, input int nb,
                          input int mode, input int hold, input bit turn_frame);
        drive(0, 1, 1, a, cmd);
        for (int b = 0; b < nb; b++) begin
            logic [31:0] d;
            logic [3:0]  be;
            bit          lst;
            d   = a ^ (32'h1357_9bdf * (b + 1));
            be  = 4'(b * 5 + 3);
            lst = (b == nb - 1);
            if (mode == 1 && b % 2 == 1) drive(0, 1, 0, 32'hdead_0000, 4'hf);
            if (mode == 2) begin
                drive(0, 0, 1, 32'hbeef_0001, 4'h0);
                drive(0, 0, 1, 32'hbeef_0002, 4'h0);
            end
            if (mode == 3 && lst) begin
                drive(1, 0, 1, 32'hcafe_0003, 4'h5);   // R11
                drive(1, 0, 1, 32'hcafe_0004, 4'h5);
            end
            drive(lst, 0, 0, d, be);
        end
        for (int h = 0; h < hold; h++) drive(turn_frame ? 0 : 1, 0, 1, 32'h0f0f_0f0f, 4'h6); // R10
        drive(turn_frame ? 0 : 1, 1, 1, 32'h0, 4'hf);  // R10: release clock, no address phase
        drive(1, 1, 1, 32'h0, 4'hf);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        drive(1, 1, 1, 0, 4'hf);
        // R3 R4 R5: sweep every command code
        for (int c = 0; c < 16; c++) do_txn(32'h1000_0000 + c * 16, 4'(c), 1, 0, 0, 0);
        do_txn(32'h2000_0040, 4'b0111, 4, 1, 0, 0);   // R7 initiator waits
        do_txn(32'h3000_0080, 4'b0110, 3, 2, 2, 0);   // R7 target waits, R9 held turnaround
        do_txn(32'h4000_00c0, 4'b1111, 2, 3, 1, 0);   // R11
        do_txn(32'h5000_0100, 4'b0011, 1, 3, 3, 1);   // R10 frame low during turnaround
        do_txn(32'h6000_0140, 4'b1110, 5, 0, 0, 0);   // R8 long burst
        // R1: reset in the middle of a burst
        drive(0, 1, 1, 32'h7000_0000, 4'b0111);
        drive(0, 0, 0, 32'h7000_0001, 4'h0);
        rst = 1;
        drive(0, 0, 0, 32'h7000_0002, 4'h0);
        drive(1, 1, 1, 0, 4'hf);
        rst = 0;
        drive(1, 1, 1, 0, 4'hf);
        do_txn(32'h8000_0000, 4'b1011, 2, 1, 0, 0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule